// File: doc/BRIEF.md
# Reorder Buffer with Precise Commit

This block keeps the results of a small pipeline in program order while its functional units finish work in any order. The decode stage asks for a slot with an allocation handshake and receives a tag, which is the slot index. Execution units later return a result and an exception flag to that tag. The oldest slot retires its result to a register-file write port once it has finished cleanly. A dependent instruction can read a finished but not yet retired value directly by tag.

When the oldest slot finishes with its exception flag set, it does not retire. In that same cycle the block raises a redirect to a handler address supplied on an input. It records the faulting instruction's PC and empties the whole buffer, so every younger instruction is dropped. The buffer is circular. Its head and tail pointers each carry a wrap bit, and it holds a power-of-two number of slots.

Allocation follows valid/ready rules: a slot is taken only in a cycle where both `alloc_valid` and `alloc_ready` are high. Retirement follows the same rules, with `commit_valid` and `commit_ready`. While `commit_ready` is low, the head stays in place and the commit outputs stay steady. Completions have no back-pressure, and the buffer accepts them in every cycle.

Top module: `rob_precise`

## Requirements
- R1: Slots are handed out in program order: each accepted allocation gets the tag one above the previous one, modulo DEPTH. After reset the first tag is 0. After a flush the next tag equals the tag of the faulting head.
- R2: With DEPTH slots occupied, `full` is 1 and `alloc_ready` is 0. `full` is 0 in every other state.
- R3: A completion (`wb_valid`) writes `wb_data` and `wb_exc` into the slot named by `wb_tag`, and completions may arrive in any order. From the following cycle, `rd_valid` is 1 for that tag and `rd_data` returns the written value until the slot retires or is flushed.
- R4: A completion whose tag names a free slot, or a slot that has already completed, has no effect. `rd_valid` stays 0 for a free slot, and a completed slot keeps its first value.
- R5: `commit_valid` is 1 exactly when the oldest slot has completed with `wb_exc`=0. In that case, `commit_dest` and `commit_data` carry that slot's destination and result.
- R6: While `commit_valid` is 1 and `commit_ready` is 0, the head does not advance and the commit outputs keep their values.
- R7: When the oldest slot has completed with `wb_exc`=1, `redirect_valid` is 1, `redirect_pc` equals `handler_pc`, and `commit_valid` is 0.
- R8: In a redirect cycle, every slot is freed and the faulting slot's PC is captured into `fault_pc`, visible from the next cycle. The buffer is empty in the following cycle.
- R9: In a redirect cycle `alloc_ready` is 0, so an allocation offered in that cycle is not taken.
- R10: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `full`=0, `commit_valid`=0, `redirect_valid`=0, `rd_valid`=0 and `fault_pc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_dest | input | REG_W | Destination register of the offered instruction |
| alloc_pc | input | PC_W | PC of the offered instruction |
| alloc_tag | output | TAG_W | Tag the offered instruction receives |
| wb_valid | input | 1 | A functional unit returns a result |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | Instruction raised an exception |
| rd_tag | input | TAG_W | Slot to read for operand pickup |
| rd_valid | output | 1 | Slot is occupied and completed |
| rd_data | output | DATA_W | Result held in that slot |
| commit_valid | output | 1 | Head is ready to retire |
| commit_ready | input | 1 | Register file accepts the write |
| commit_dest | output | REG_W | Register written at retirement |
| commit_data | output | DATA_W | Value written at retirement |
| handler_pc | input | PC_W | Exception handler address |
| redirect_valid | output | 1 | Fetch must restart at the handler |
| redirect_pc | output | PC_W | Address to fetch from |
| fault_pc | output | PC_W | PC of the last faulting instruction |
| full | output | 1 | All slots occupied |

## Verification
The bench first fills the buffer with no completions, which shows that allocation is refused at DEPTH slots. It then completes the slots youngest first while retirement is held back. This separates a buffer that retires in order from one that retires by completion order, and it shows the head holding under back-pressure. A long random phase mixes allocation, stalls, completions to live, free and already-finished tags, and occasional exceptions. This exposes wrap-around tag errors and shows whether a late completion can disturb a freed or finished slot. It also tests whether a flush drops every younger slot and blocks an allocation offered in the same cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HS_EMPTY  = 2'd0,
    HS_BUSY   = 2'd1,
    HS_RETIRE = 2'd2,
    HS_FAULT  = 2'd3
  } head_state_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic                     flush,
  output logic [$clog2(DEPTH)-1:0] head_idx,
  output logic [$clog2(DEPTH)-1:0] tail_idx,
  output logic                     full,
  output logic                     empty
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;

  logic [PW-1:0] head_q, tail_q, occ;

  assign occ      = tail_q - head_q;
  assign head_idx = head_q[IW-1:0];
  assign tail_idx = tail_q[IW-1:0];
  assign full     = (occ == PW'(DEPTH));
  assign empty    = (occ == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      tail_q <= head_q;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> occ == $past(occ) + 1'b1);
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     alloc_en,
  input  logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic [REG_W-1:0]         alloc_dest,
  input  logic [PC_W-1:0]          alloc_pc,
  input  logic                     wb_en,
  input  logic [$clog2(DEPTH)-1:0] wb_idx,
  input  logic [DATA_W-1:0]        wb_data,
  input  logic                     wb_exc,
  input  logic                     pop_en,
  input  logic [$clog2(DEPTH)-1:0] head_idx,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     rd_ok,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     head_valid,
  output logic                     head_done,
  output logic                     head_exc,
  output logic [REG_W-1:0]         head_dest,
  output logic [DATA_W-1:0]        head_data,
  output logic [PC_W-1:0]          head_pc
);
  localparam int IW = $clog2(DEPTH);

  logic              valid_q [DEPTH];
  logic              done_q  [DEPTH];
  logic              exc_q   [DEPTH];
  logic [DATA_W-1:0] data_q  [DEPTH];
  logic [REG_W-1:0]  dest_q  [DEPTH];
  logic [PC_W-1:0]   pc_q    [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic take, fill, drop;
    assign take = alloc_en && (alloc_idx == IW'(i));
    assign fill = wb_en && (wb_idx == IW'(i)) && valid_q[i] && !done_q[i];
    assign drop = pop_en && (head_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        exc_q[i]   <= 1'b0;
        data_q[i]  <= '0;
        dest_q[i]  <= '0;
        pc_q[i]    <= '0;
      end else if (flush) begin
        valid_q[i] <= 1'b0;
      end else begin
        if (drop) valid_q[i] <= 1'b0;
        if (take) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
          exc_q[i]   <= 1'b0;
          dest_q[i]  <= alloc_dest;
          pc_q[i]    <= alloc_pc;
        end
        if (fill) begin
          done_q[i] <= 1'b1;
          exc_q[i]  <= wb_exc;
          data_q[i] <= wb_data;
        end
      end
    end

    assert_stray_wb_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && wb_idx == IW'(i) && (!valid_q[i] || done_q[i])) |=> $stable(data_q[i]));
  end

  assign rd_ok      = valid_q[rd_idx] && done_q[rd_idx];
  assign rd_data    = data_q[rd_idx];
  assign head_valid = valid_q[head_idx];
  assign head_done  = done_q[head_idx];
  assign head_exc   = exc_q[head_idx];
  assign head_dest  = dest_q[head_idx];
  assign head_data  = data_q[head_idx];
  assign head_pc    = pc_q[head_idx];
endmodule

// File: rtl/rob_precise.sv
module rob_precise
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              commit_valid,
  input  logic              commit_ready,
  output logic [REG_W-1:0]  commit_dest,
  output logic [DATA_W-1:0] commit_data,
  input  logic [PC_W-1:0]   handler_pc,
  output logic              redirect_valid,
  output logic [PC_W-1:0]   redirect_pc,
  output logic [PC_W-1:0]   fault_pc,
  output logic              full
);
  logic [TAG_W-1:0] head_idx, tail_idx;
  logic             empty, push, pop, flush;
  logic             h_valid, h_done, h_exc;
  logic [PC_W-1:0]  h_pc;
  logic [PC_W-1:0]  fault_pc_q;
  head_state_e      hstate;

  always_comb begin
    if (!h_valid)    hstate = HS_EMPTY;
    else if (!h_done) hstate = HS_BUSY;
    else if (h_exc)   hstate = HS_FAULT;
    else              hstate = HS_RETIRE;
  end

  assign flush          = (hstate == HS_FAULT);
  assign commit_valid   = (hstate == HS_RETIRE);
  assign pop            = commit_valid && commit_ready;
  assign alloc_ready    = !full && !flush;
  assign push           = alloc_valid && alloc_ready;
  assign alloc_tag      = tail_idx;
  assign redirect_valid = flush;
  assign redirect_pc    = handler_pc;
  assign fault_pc       = fault_pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fault_pc_q <= '0;
    else if (flush) fault_pc_q <= h_pc;
  end

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
  );

  rob_entry_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .PC_W(PC_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_en(push), .alloc_idx(tail_idx), .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .wb_en(wb_valid), .wb_idx(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
    .pop_en(pop), .head_idx(head_idx), .rd_idx(rd_tag),
    .rd_ok(rd_valid), .rd_data(rd_data),
    .head_valid(h_valid), .head_done(h_done), .head_exc(h_exc),
    .head_dest(commit_dest), .head_data(commit_data), .head_pc(h_pc)
  );

  assert_tag_sequence_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_tag == TAG_W'($past(alloc_tag) + 1'b1));
  assert_commit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready) |=>
      commit_valid && $stable(commit_dest) && $stable(commit_data));
  assert_flush_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !commit_valid && !redirect_valid && empty);
  assert_empty_no_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !commit_valid && !redirect_valid);
endmodule

// File: tb/rob_precise_test.sv
`timescale 1ns/1ps
module rob_precise_test;
  localparam int DEPTH = 8, DW = 32, RW = 5, PW = 32, TW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready;
  logic [RW-1:0] alloc_dest = '0;
  logic [PW-1:0] alloc_pc = '0;
  logic [TW-1:0] alloc_tag;
  logic wb_valid = 0, wb_exc = 0;
  logic [TW-1:0] wb_tag = '0, rd_tag = '0;
  logic [DW-1:0] wb_data = '0, rd_data, commit_data;
  logic rd_valid, commit_valid, commit_ready = 0, redirect_valid, full;
  logic [RW-1:0] commit_dest;
  logic [PW-1:0] handler_pc = 32'h0000_0180, redirect_pc, fault_pc;

  rob_precise #(.DEPTH(DEPTH), .DATA_W(DW), .REG_W(RW), .PC_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dest(alloc_dest), .alloc_pc(alloc_pc), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_data(rd_data),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_dest(commit_dest), .commit_data(commit_data),
    .handler_pc(handler_pc), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .fault_pc(fault_pc), .full(full)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference: program-order queue of tags plus per-tag records
  int order[$];
  int nxt;
  logic [RW-1:0] m_dest [DEPTH];
  logic [PW-1:0] m_pc   [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  bit m_done [DEPTH];
  bit m_exc  [DEPTH];
  logic [PW-1:0] m_fault;

  function automatic bit live(int t);
    foreach (order[k]) if (order[k] == t) return 1'b1;
    return 1'b0;
  endfunction
  function automatic bit e_redirect();
    return order.size() > 0 && m_done[order[0]] && m_exc[order[0]];
  endfunction
  function automatic bit e_commit();
    return order.size() > 0 && m_done[order[0]] && !m_exc[order[0]];
  endfunction
  function automatic bit e_ready();
    return order.size() < DEPTH && !e_redirect();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      order.delete(); nxt = 0; m_fault = '0;
    end else begin
      bit fl, pp, al;
      fl = e_redirect();
      pp = e_commit() && commit_ready;
      al = alloc_valid && e_ready();
      if (wb_valid && live(int'(wb_tag)) && !m_done[wb_tag]) begin
        m_done[wb_tag] = 1'b1; m_exc[wb_tag] = wb_exc; m_data[wb_tag] = wb_data;
      end
      if (fl) begin
        m_fault = m_pc[order[0]]; nxt = order[0]; order.delete();
      end else begin
        if (pp) void'(order.pop_front());
        if (al) begin
          order.push_back(nxt);
          m_dest[nxt] = alloc_dest; m_pc[nxt] = alloc_pc;
          m_done[nxt] = 1'b0; m_exc[nxt] = 1'b0;
          nxt = (nxt + 1) % DEPTH;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit rdv;
    chk("R2 R9", "alloc_ready", 64'(alloc_ready), 64'(e_ready()));
    chk("R1", "alloc_tag", 64'(alloc_tag), 64'(nxt));
    chk("R2", "full", 64'(full), 64'(order.size() == DEPTH));
    chk("R5 R6", "commit_valid", 64'(commit_valid), 64'(e_commit()));
    if (e_commit()) begin
      chk("R5", "commit_dest", 64'(commit_dest), 64'(m_dest[order[0]]));
      chk("R5", "commit_data", 64'(commit_data), 64'(m_data[order[0]]));
    end
    chk("R7", "redirect_valid", 64'(redirect_valid), 64'(e_redirect()));
    if (e_redirect()) chk("R7", "redirect_pc", 64'(redirect_pc), 64'(handler_pc));
    chk("R8", "fault_pc", 64'(fault_pc), 64'(m_fault));
    rdv = live(int'(rd_tag)) && m_done[rd_tag];
    chk("R3 R4", "rd_valid", 64'(rd_valid), 64'(rdv));
    if (rdv) chk("R3", "rd_data", 64'(rd_data), 64'(m_data[rd_tag]));
  endtask

  task automatic drive(int cyc);
    if (cyc < 12) begin                 // fill past capacity: R2 refusal
      alloc_valid = 1; alloc_dest = RW'(cyc + 1); alloc_pc = PW'(32'h1000 + 4 * cyc);
      wb_valid = 0; commit_ready = 1; rd_tag = TW'(cyc);
    end else if (cyc < 20) begin        // complete youngest first, retire held: R3 R6
      alloc_valid = 0; wb_valid = 1; wb_tag = TW'(19 - cyc);
      wb_data = 32'hA000 + cyc; wb_exc = 0; commit_ready = 0; rd_tag = TW'(19 - cyc);
    end else if (cyc < 24) begin        // stray writes to completed tags: R4
      wb_valid = 1; wb_tag = TW'(cyc); wb_data = 32'hDEAD; commit_ready = (cyc >= 22);
      rd_tag = TW'(cyc);
    end else begin                      // random mix with exceptions: R7 R8 R9
      alloc_valid = ($urandom % 4) != 0;
      alloc_dest = RW'($urandom); alloc_pc = {$urandom, 2'b00};
      commit_ready = ($urandom % 5) != 0;
      wb_valid = ($urandom % 3) != 0;
      if (order.size() > 0 && ($urandom % 4) != 0) wb_tag = TW'(order[$urandom % order.size()]);
      else wb_tag = TW'($urandom);
      wb_data = $urandom; wb_exc = ($urandom % 20) == 0;
      rd_tag = TW'($urandom);
      if (($urandom % 64) == 0) handler_pc = {$urandom, 2'b00};
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R10", "alloc_tag", 64'(alloc_tag), 64'd0);
    chk("R10", "full", 64'(full), 64'd0);
    chk("R10", "commit_valid", 64'(commit_valid), 64'd0);
    chk("R10", "redirect_valid", 64'(redirect_valid), 64'd0);
    chk("R10", "rd_valid", 64'(rd_valid), 64'd0);
    chk("R10", "fault_pc", 64'(fault_pc), 64'd0);
    rst_n = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      compare_all();
      drive(cyc);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule